// File: doc/BRIEF.md
# LCD Multiplex Backplane Sequencer

This block turns a stored display bit map into per-time-slot drive codes for four common (backplane) lines and a parameterised number of segment lines of a passive liquid-crystal panel. A frame is divided into one to four time slots, one per bit-map row in use. In each slot one row's backplanes sit at the active rail and every segment is driven either against that rail (element on) or with it (element off). The codes are symbolic levels for a downstream analog stage; no voltages are produced here.

The bit map is read through a single-port column read interface. After reset, and again after every frame boundary at which it takes new data, the block sweeps all columns into a shadow copy while the current frame keeps being shown from a separate display register. The display register takes the shadow copy only at a frame boundary and only once the sweep is complete, so a frame never mixes old and new data. The drive mode is also taken only at frame boundaries. Each frame runs with the opposite polarity of the one before it, which keeps the drive balanced over two frames.

Top module: `lcd_bp_sequencer`

## Requirements
- R1: After reset the block is in the one-row mode, in slot 0, with positive polarity and an all-zero display register: every backplane and every segment code is 2'b11 and frame_o is 0.
- R2: mode_i selects the number of rows per frame as mode_i+1 (0: one row, 1: two, 2: three, 3: four). Each cycle with tick_i high advances the slot by one; a tick in the last slot returns to slot 0 and frame_o is high for exactly the following cycle. frame_o is low in every other cycle.
- R3: mode_i is sampled only on a tick that ends a frame; changing it inside a frame has no effect on the slots of that frame.
- R4: The polarity toggles at every frame boundary.
- R5: Level codes are 2'b11 high rail, 2'b00 low rail, 2'b01 lower middle level, 2'b10 upper middle level. The active rail is 2'b11 in positive polarity and 2'b00 in negative polarity. A backplane whose row equals the current slot is at the active rail; every other backplane is at 2'b01 (positive) or 2'b10 (negative).
- R6: Backplane p (0..3) serves row p in four-row mode; in three-row mode backplane 3 serves row 1 and the others their own index; in two-row mode backplane p serves row p mod 2; in one-row mode all four serve row 0.
- R7: In slot s, segment k (code at seg_lvl_o[2k+1:2k]) is the inverse of the active rail when bit s of column k in the display register is 1, and equal to the active rail when it is 0.
- R8: The read port takes a column address on ram_addr_o and returns that column one cycle later on ram_data_i, bit n holding row n. A sweep presents columns 0 to NUM_SEG-1 on consecutive cycles, starting right after reset and right after each loading boundary, and is complete NUM_SEG+1 cycles after it starts; ram_addr_o is 0 outside a sweep.
- R9: The display register changes only at a frame boundary and then takes the data of the last complete sweep; bit-map changes made after a sweep has read them appear only after the next loading boundary.
- R10: A frame boundary reached while a sweep is still running leaves the display register unchanged and lets the sweep run on; the next boundary after it completes performs the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slot-advance enable, one cycle per slot period |
| mode_i | input | 2 | Row count selector (rows = mode_i + 1) |
| ram_addr_o | output | 6 | Bit-map column address for the read port |
| ram_data_i | input | 4 | Column data, returned one cycle after the address, bit n = row n |
| bp_lvl_o | output | 8 | Backplane level codes, 2 bits per backplane, backplane 0 in bits 1:0 |
| seg_lvl_o | output | 80 | Segment level codes, 2 bits per segment, segment 0 in bits 1:0 |
| frame_o | output | 1 | One-cycle pulse after the tick that ends a frame |

## Verification
The embedded properties watch, on every cycle, that the slot stays inside the active row count, that the mode and the display register hold between frame boundaries, that polarity flips whenever a frame starts, that addresses stay in range, and that the backplane pairing of each mode holds at the outputs with exactly one active backplane in four-row mode. Only the bench scenarios can show that the segment codes carry the right row of the right snapshot in each slot, that a bit-map change made mid-frame is deferred by a full frame, that a mode request inside a frame waits for its end, and that a boundary hit during an unfinished sweep skips the load.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

   // geometry fixed by the backplane mapping
   localparam int unsigned NUM_ROW = 4;
   localparam int unsigned NUM_BP  = 4;
   localparam int unsigned SLOT_W  = $clog2(NUM_ROW);

   // row-count selector: rows = mode + 1
   localparam logic [1:0] MODE_ONE   = 2'd0;
   localparam logic [1:0] MODE_TWO   = 2'd1;
   localparam logic [1:0] MODE_THREE = 2'd2;
   localparam logic [1:0] MODE_FOUR  = 2'd3;

   // symbolic drive levels
   localparam logic [1:0] LVL_LO   = 2'b00;
   localparam logic [1:0] LVL_MIDL = 2'b01;
   localparam logic [1:0] LVL_MIDH = 2'b10;
   localparam logic [1:0] LVL_HI   = 2'b11;

   // row served by a backplane in a given mode
   function automatic logic [SLOT_W-1:0] bp_row(input logic [1:0] mode, input int unsigned bp);
      logic [SLOT_W-1:0] idx;
      idx = SLOT_W'(bp);
      case (mode)
         MODE_FOUR:  bp_row = idx;
         MODE_THREE: bp_row = (idx == SLOT_W'(3)) ? SLOT_W'(1) : idx;
         MODE_TWO:   bp_row = {1'b0, idx[0]};
         default:    bp_row = '0;
      endcase
   endfunction

endpackage

// File: rtl/lcd_slot_timer.sv
module lcd_slot_timer
   import lcd_seq_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic [1:0]        mode_i,
   output logic [SLOT_W-1:0] slot_o,
   output logic              pol_o,
   output logic [1:0]        mode_o,
   output logic              frame_o,
   output logic              bnd_o
);

   logic [SLOT_W-1:0] slot_q;
   logic              pol_q;
   logic [1:0]        mode_q;
   logic              frame_q;
   logic              last_slot;

   // last slot index equals the mode code (rows - 1)
   assign last_slot = (slot_q == SLOT_W'(mode_q));
   assign bnd_o     = tick_i && last_slot;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         slot_q  <= '0;
         pol_q   <= 1'b0;
         mode_q  <= MODE_ONE;
         frame_q <= 1'b0;
      end else begin
         frame_q <= 1'b0;
         if (tick_i) begin
            if (last_slot) begin
               slot_q  <= '0;
               pol_q   <= ~pol_q;
               mode_q  <= mode_i;
               frame_q <= 1'b1;
            end else begin
               slot_q <= slot_q + 1'b1;
            end
         end
      end
   end

   assign slot_o  = slot_q;
   assign pol_o   = pol_q;
   assign mode_o  = mode_q;
   assign frame_o = frame_q;

   // R2: slot never leaves the active row range
   p_slot_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_q <= SLOT_W'(mode_q));

   // R3: mode is held unless a frame ends
   p_mode_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bnd_o |=> $stable(mode_q));

   // R4: every new frame has flipped polarity
   p_pol_flip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bnd_o |=> (pol_q != $past(pol_q)));

   // R2: the frame pulse always coincides with slot 0
   p_frame_slot0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_q |-> (slot_q == '0));

endmodule

// File: rtl/lcd_disp_loader.sv
module lcd_disp_loader
   import lcd_seq_pkg::*;
#(
   parameter int unsigned NUM_SEG = 40,
   localparam int unsigned COL_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
   localparam int unsigned CNT_W  = $clog2(NUM_SEG + 1),
   localparam int unsigned DISP_W = NUM_SEG * NUM_ROW
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               bnd_i,
   output logic [COL_W-1:0]   ram_addr_o,
   input  logic [NUM_ROW-1:0] ram_data_i,
   output logic [DISP_W-1:0]  disp_o
);

   logic [CNT_W-1:0]   cnt_q;
   logic               rd_vld_q;
   logic [COL_W-1:0]   rd_col_q;
   logic               issuing;
   logic               sweep_done;
   logic [NUM_ROW-1:0] shadow_q [NUM_SEG];
   logic [DISP_W-1:0]  shadow_flat;
   logic [DISP_W-1:0]  disp_q;

   assign issuing    = (cnt_q < CNT_W'(NUM_SEG));
   assign sweep_done = !issuing && !rd_vld_q;
   assign ram_addr_o = issuing ? cnt_q[COL_W-1:0] : '0;

   // address sequencer and read pipeline
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         rd_vld_q <= 1'b0;
         rd_col_q <= '0;
      end else begin
         rd_vld_q <= issuing;
         rd_col_q <= cnt_q[COL_W-1:0];
         if (bnd_i && sweep_done) begin
            cnt_q <= '0;
         end else if (issuing) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // shadow copy, one column per register group
   for (genvar k = 0; k < NUM_SEG; k++) begin : g_col
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            shadow_q[k] <= '0;
         end else if (rd_vld_q && (rd_col_q == COL_W'(k))) begin
            shadow_q[k] <= ram_data_i;
         end
      end
      assign shadow_flat[k*NUM_ROW +: NUM_ROW] = shadow_q[k];
   end

   // display register: frame-boundary load of a finished sweep
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         disp_q <= '0;
      end else if (bnd_i && sweep_done) begin
         disp_q <= shadow_flat;
      end
   end

   assign disp_o = disp_q;

   // R9: the shown data only changes on a frame boundary
   p_disp_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bnd_i |=> $stable(disp_q));

   // R10: a boundary during a sweep does not restart it
   p_sweep_runs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bnd_i && issuing) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R8: addresses stay within the bit map
   p_addr_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ram_addr_o < COL_W'(NUM_SEG));

endmodule

// File: rtl/lcd_drive_encoder.sv
module lcd_drive_encoder
   import lcd_seq_pkg::*;
#(
   parameter int unsigned NUM_SEG = 40,
   localparam int unsigned DISP_W = NUM_SEG * NUM_ROW
) (
   input  logic [SLOT_W-1:0]    slot_i,
   input  logic                 pol_i,
   input  logic [1:0]           mode_i,
   input  logic [DISP_W-1:0]    disp_i,
   output logic [2*NUM_BP-1:0]  bp_lvl_o,
   output logic [2*NUM_SEG-1:0] seg_lvl_o
);

   logic [1:0] act_lvl;
   logic [1:0] inv_lvl;
   logic [1:0] idle_lvl;

   assign act_lvl  = pol_i ? LVL_LO : LVL_HI;
   assign inv_lvl  = pol_i ? LVL_HI : LVL_LO;
   assign idle_lvl = pol_i ? LVL_MIDH : LVL_MIDL;

   for (genvar p = 0; p < NUM_BP; p++) begin : g_bp
      logic [SLOT_W-1:0] row;
      assign row = bp_row(mode_i, p);
      assign bp_lvl_o[2*p +: 2] = (row == slot_i) ? act_lvl : idle_lvl;
   end

   for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
      logic [NUM_ROW-1:0] col;
      assign col = disp_i[k*NUM_ROW +: NUM_ROW];
      assign seg_lvl_o[2*k +: 2] = col[slot_i] ? inv_lvl : act_lvl;
   end

endmodule

// File: rtl/lcd_bp_sequencer.sv
module lcd_bp_sequencer
   import lcd_seq_pkg::*;
#(
   parameter int unsigned NUM_SEG = 40,
   localparam int unsigned COL_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
   localparam int unsigned DISP_W = NUM_SEG * NUM_ROW
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 tick_i,
   input  logic [1:0]           mode_i,
   output logic [COL_W-1:0]     ram_addr_o,
   input  logic [3:0]           ram_data_i,
   output logic [7:0]           bp_lvl_o,
   output logic [2*NUM_SEG-1:0] seg_lvl_o,
   output logic                 frame_o
);

   initial begin : elab_chk
      assert (NUM_SEG >= 1 && NUM_SEG <= 256)
         else $error("NUM_SEG must be in 1..256");
      assert (NUM_ROW == 4 && NUM_BP == 4)
         else $error("row and backplane count must both be 4");
   end

   logic [SLOT_W-1:0] slot;
   logic              pol;
   logic [1:0]        mode_q;
   logic              bnd;
   logic [DISP_W-1:0] disp;

   lcd_slot_timer u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .mode_i  (mode_i),
      .slot_o  (slot),
      .pol_o   (pol),
      .mode_o  (mode_q),
      .frame_o (frame_o),
      .bnd_o   (bnd)
   );

   lcd_disp_loader #(.NUM_SEG(NUM_SEG)) u_loader (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .bnd_i      (bnd),
      .ram_addr_o (ram_addr_o),
      .ram_data_i (ram_data_i),
      .disp_o     (disp)
   );

   lcd_drive_encoder #(.NUM_SEG(NUM_SEG)) u_enc (
      .slot_i    (slot),
      .pol_i     (pol),
      .mode_i    (mode_q),
      .disp_i    (disp),
      .bp_lvl_o  (bp_lvl_o),
      .seg_lvl_o (seg_lvl_o)
   );

   // backplanes sitting at a rail (active) as seen at the outputs
   logic [NUM_BP-1:0] bp_rail;
   for (genvar p = 0; p < NUM_BP; p++) begin : g_rail
      assign bp_rail[p] = (bp_lvl_o[2*p +: 2] == LVL_HI) || (bp_lvl_o[2*p +: 2] == LVL_LO);
   end

   // R6: three-row pairing
   p_pair_three_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == MODE_THREE) |-> (bp_lvl_o[7:6] == bp_lvl_o[3:2]));

   // R6: two-row pairing
   p_pair_two_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == MODE_TWO) |-> ((bp_lvl_o[5:4] == bp_lvl_o[1:0]) && (bp_lvl_o[7:6] == bp_lvl_o[3:2])));

   // R6: one-row mode drives all backplanes identically, at the rail
   p_pair_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == MODE_ONE) |-> (bp_rail == '1 && bp_lvl_o[7:6] == bp_lvl_o[1:0]
                                && bp_lvl_o[5:4] == bp_lvl_o[1:0] && bp_lvl_o[3:2] == bp_lvl_o[1:0]));

   // R5: exactly one backplane active per slot with four rows
   p_one_active_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == MODE_FOUR) |-> ($countones(bp_rail) == 1));

endmodule

// File: tb/tb_lcd_bp_sequencer.sv
module tb_lcd_bp_sequencer;

   localparam int NSEG = 40;

   typedef struct {
      logic [7:0]        bp;
      logic [2*NSEG-1:0] seg;
      logic              frm;
      logic              ld;
      string             tag;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick = 1'b0;
   logic              tick_d = 1'b0;
   logic [1:0]        mode = 2'd0;
   logic [5:0]        ram_addr;
   logic [3:0]        ram_data = 4'h0;
   logic [7:0]        bp_lvl;
   logic [2*NSEG-1:0] seg_lvl;
   logic              frame;

   int n_chk = 0;
   int n_bad = 0;
   int edge_n = 0;
   bit finished = 0;

   logic [3:0] mem     [NSEG];
   logic [3:0] m_disp  [NSEG];
   logic [3:0] m_shad  [NSEG];
   int         m_slot = 0;
   logic       m_pol = 1'b0;
   logic [1:0] m_mode = 2'd0;
   int         m_restart = 0;
   item_t      q[$];

   always #5 clk = ~clk;

   lcd_bp_sequencer dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .tick_i     (tick),
      .mode_i     (mode),
      .ram_addr_o (ram_addr),
      .ram_data_i (ram_data),
      .bp_lvl_o   (bp_lvl),
      .seg_lvl_o  (seg_lvl),
      .frame_o    (frame)
   );

   // bit-map model with one-cycle read latency (R8)
   always @(posedge clk) begin
      ram_data <= (int'(ram_addr) < NSEG) ? mem[ram_addr] : 4'h0;
      tick_d   <= tick;
      edge_n   <= edge_n + 1;
   end

   task automatic check(input bit ok, input string tag, input string act, input string exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%s expected=%s", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] pat(input int seed, input int k);
      return 4'((k * 7 + seed * 5 + (k >> 2) * seed + seed * seed) & 15);
   endfunction

   task automatic set_mem(input int seed);
      for (int k = 0; k < NSEG; k++) mem[k] = pat(seed, k);
   endtask

   function automatic int bprow(input logic [1:0] md, input int p);
      case (md)
         2'd3: return p;
         2'd2: return (p == 3) ? 1 : p;
         2'd1: return p % 2;
         default: return 0;
      endcase
   endfunction

   task automatic expect_now(input bit frm, input bit ld, input string tag);
      item_t it;
      logic [1:0] act, inv, idl;
      act = m_pol ? 2'b00 : 2'b11;
      inv = m_pol ? 2'b11 : 2'b00;
      idl = m_pol ? 2'b10 : 2'b01;
      for (int p = 0; p < 4; p++)
         it.bp[2*p +: 2] = (bprow(m_mode, p) == m_slot) ? act : idl;
      for (int k = 0; k < NSEG; k++)
         it.seg[2*k +: 2] = m_disp[k][m_slot] ? inv : act;
      it.frm = frm;
      it.ld  = ld;
      it.tag = tag;
      q.push_back(it);
   endtask

   // driver: one tick, model update, expected item queued
   task automatic step(input int gap, input string tag);
      int eb;
      bit bnd, ld;
      eb  = edge_n + 1;
      bnd = (m_slot == int'(m_mode));
      ld  = 1'b0;
      if (bnd) begin
         m_slot = 0;
         m_pol  = ~m_pol;
         m_mode = mode;
         if (eb - m_restart >= NSEG + 1) begin
            for (int k = 0; k < NSEG; k++) begin
               m_disp[k] = m_shad[k];
               m_shad[k] = mem[k];
            end
            m_restart = eb;
            ld = 1'b1;
         end
      end else begin
         m_slot++;
      end
      expect_now(bnd, ld, tag);
      tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tick = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic run_frame(input string tag);
      do step(50, tag); while (m_slot != 0);
   endtask

   // monitor: compares each slot update against the queue
   always @(negedge clk) begin
      if (rst_n && tick_d) begin
         if (q.size() == 0) begin
            check(1'b0, "R2 queue", "empty", "item");
         end else begin
            item_t it;
            it = q.pop_front();
            check(bp_lvl == it.bp, {it.tag, " backplanes R5 R6"},
                  $sformatf("%h", bp_lvl), $sformatf("%h", it.bp));
            check(seg_lvl == it.seg, {it.tag, " segments R7 R9"},
                  $sformatf("%h", seg_lvl), $sformatf("%h", it.seg));
            check(frame == it.frm, {it.tag, " frame pulse R2"},
                  $sformatf("%0b", frame), $sformatf("%0b", it.frm));
            if (it.ld)
               check(ram_addr == 6'd0, {it.tag, " sweep restart R8"},
                     $sformatf("%0d", ram_addr), "0");
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      set_mem(1);
      for (int k = 0; k < NSEG; k++) m_disp[k] = 4'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_restart = edge_n;
      for (int k = 0; k < NSEG; k++) m_shad[k] = mem[k];
      repeat (60) @(negedge clk);

      // R1: reset state
      check(bp_lvl == 8'hFF, "R1 backplanes", $sformatf("%h", bp_lvl), "ff");
      check(seg_lvl == '1, "R1 segments", $sformatf("%h", seg_lvl), "all ones");
      check(frame == 1'b0, "R1 frame", $sformatf("%0b", frame), "0");
      check(ram_addr == 6'd0, "R8 idle address", $sformatf("%0d", ram_addr), "0");

      // one-row frames, first load, polarity alternation (R4)
      run_frame("R4 one-row a");
      run_frame("R4 one-row b");

      // switch to four rows at the next boundary (R2)
      mode = 2'd3;
      run_frame("R2 enter four-row");
      run_frame("R2 four-row a");
      run_frame("R2 four-row b");
      set_mem(2);
      run_frame("R9 four-row new map");
      run_frame("R9 four-row shows map2");

      // R3: mode request mid-frame is held to the boundary
      step(50, "R3 slot1");
      mode = 2'd1;
      step(50, "R3 slot2 old mode");
      step(50, "R3 slot3 old mode");
      step(50, "R3 boundary to two-row");
      run_frame("R6 two-row a");
      set_mem(3);
      run_frame("R6 two-row b");

      mode = 2'd2;
      run_frame("R6 to three-row");
      run_frame("R6 three-row a");

      // R9: map change after the sweep, mid-frame
      step(50, "R9 three-row slot1");
      set_mem(4);
      step(50, "R9 three-row slot2");
      step(50, "R9 boundary old snapshot");
      run_frame("R9 three-row shows map4");

      // R10: boundaries during an unfinished sweep skip the load
      mode = 2'd0;
      run_frame("R10 to one-row");
      set_mem(5);
      step(3, "R10 load boundary");
      step(3, "R10 early boundary a");
      step(50, "R10 early boundary b");
      step(50, "R10 late boundary loads");
      step(50, "R10 steady");

      repeat (5) @(negedge clk);
      check(q.size() == 0, "R2 all slots observed", $sformatf("%0d", q.size()), "0");
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule